// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast clock by a programmable ratio N = B·P + A and emits one single-cycle pulse per N input cycles, for use as the feedback input of a phase detector. It does not use one plain modulo counter. An inner prescaler counts either P or P+1 cycles per period. A swallow counter decides which modulus the prescaler uses. A main counter sets how many prescaler periods make one output period. The prescaler is modelled as synchronous logic in the same clock domain as the rest of the block.

Each output period holds B prescaler periods. The first A of them are P+1 cycles long and the remaining B−A are P cycles long. The modulus P is 8, 16, 32 or 64, picked by a 2-bit select. Settings are sampled only where one output period ends and the next begins. A setting that breaks the legal range is flagged and ignored, and the last valid ratio stays in force. The smallest ratio at which every integer setting above it is reachable is P² − P.

Top module: `pulse_swallow_divider`

## Requirements
- R1: `divOut` is high for exactly one clock cycle per output period, and consecutive rising edges of `divOut` are B·P + A clock cycles apart for the active setting.
- R2: `preSel` selects the modulus pair: 0 gives P=8, 1 gives P=16, 2 gives P=32, 3 gives P=64. The long prescaler period is always P+1 cycles.
- R3: The boundary settings A = 0 (interval B·P) and A = B (interval B·(P+1)) are both legal and give the ratio stated in R1.
- R4: Within one output period, the number of prescaler periods still to be lengthened never exceeds the number of prescaler periods still to run.
- R5: `cfgBad` is 1, combinationally from the inputs, exactly when `bLoad` < 3 or `aLoad` > `bLoad`. Otherwise it is 0.
- R6: While the inputs are invalid as defined in R5, the divider keeps running at the last valid ratio.
- R7: New `preSel`, `bLoad` and `aLoad` values take effect only at the end of an output period. The period in progress keeps the length of the setting it started with.
- R8: `rst` is synchronous and active high. While it is high, `divOut` is 0. At reset the divider loads the inputs if they are valid, and otherwise loads P=8, B=3, A=0 (N=24). The first pulse comes N cycles after the last clock edge at which `rst` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| preSel | input | 2 | Prescaler modulus select (P = 8 << preSel) |
| bLoad | input | 13 | Main counter setting B, legal 3 to 8191 |
| aLoad | input | 6 | Swallow counter setting A, legal 0 to min(63, B) |
| divOut | output | 1 | One-cycle divided output pulse |
| cfgBad | output | 1 | High while the input setting is illegal |

## Verification
The assertions check several properties on every cycle. The divided pulse never lasts two cycles. The main counter never reaches zero. The remaining swallow count never exceeds the remaining main count. The prescaler count stays within the active modulus. The stored setting changes only at a period boundary. The bench scenarios cover the properties that need whole periods to show. They measure pulse-to-pulse intervals across all four moduli, with A = 0 and A = B among the settings. They show that the in-progress period keeps its old length after a mid-period change. They show that invalid settings leave the ratio unchanged, and that reset falls back to the default ratio when the inputs are illegal.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int P_BASE = 8;
  localparam int SEL_W  = 2;
  localparam int P_MAX  = P_BASE << ((1 << SEL_W) - 1);
  localparam int PC_W   = $clog2(P_MAX) + 1;

  typedef struct packed {
    logic frameEnd;   // last prescaler period of an output period ends now
    logic nextWide;   // prescaler period being started lasts P+1 cycles
  } psdStrobe_t;

  function automatic logic [PC_W-1:0] modOf(input logic [SEL_W-1:0] s);
    return PC_W'(P_BASE) << s;
  endfunction
endpackage

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int BW      = 13,
  parameter int AW      = 6,
  parameter int MIN_B   = 3,
  parameter int DEF_B   = 3,
  parameter int DEF_A   = 0,
  parameter int DEF_SEL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] preSel,
  input  logic [BW-1:0]    bIn,
  input  logic [AW-1:0]    aIn,
  input  psdStrobe_t       stb,
  output logic             preEnd,
  output logic [BW-1:0]    nextB,
  output logic [AW-1:0]    nextA,
  output logic             divOut,
  output logic             cfgBad
);
  logic [SEL_W-1:0] actSel, nextSel;
  logic [BW-1:0]    actB;
  logic [AW-1:0]    actA;
  logic [PC_W-1:0]  preCnt, pNow, pNext;
  logic             inValid;

  assign inValid = (bIn >= BW'(MIN_B)) && (BW'(aIn) <= bIn);
  assign cfgBad  = !inValid;

  always_comb begin
    if (inValid) begin
      nextSel = preSel;
      nextB   = bIn;
      nextA   = aIn;
    end else if (rst) begin
      nextSel = SEL_W'(DEF_SEL);
      nextB   = BW'(DEF_B);
      nextA   = AW'(DEF_A);
    end else begin
      nextSel = actSel;
      nextB   = actB;
      nextA   = actA;
    end
  end

  assign pNow   = modOf(actSel);
  assign pNext  = modOf(nextSel);
  assign preEnd = (preCnt == '0);

  always_ff @(posedge clk) begin
    if (rst || stb.frameEnd) begin
      actSel <= nextSel;
      actB   <= nextB;
      actA   <= nextA;
      preCnt <= stb.nextWide ? pNext : pNext - PC_W'(1);
    end else if (preEnd) begin
      preCnt <= stb.nextWide ? pNow : pNow - PC_W'(1);
    end else begin
      preCnt <= preCnt - PC_W'(1);
    end
    divOut <= stb.frameEnd;
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    divOut |=> !divOut);
  a_r2_prescaler_range: assert property (@(posedge clk) disable iff (rst)
    preCnt <= pNow);
  a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !stb.frameEnd |=> ($stable(actSel) && $stable(actB) && $stable(actA)));
endmodule

// File: rtl/psd_control.sv
module psd_control
  import psd_pkg::*;
#(
  parameter int BW = 13,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          preEnd,
  input  logic [BW-1:0] nextB,
  input  logic [AW-1:0] nextA,
  output psdStrobe_t    stb
);
  logic [BW-1:0] bCnt;   // prescaler periods left, current one included
  logic [AW-1:0] aCnt;   // long periods left, current one included
  logic          reload;

  assign stb.frameEnd = !rst && preEnd && (bCnt == BW'(1));
  assign reload       = rst || stb.frameEnd;
  assign stb.nextWide = reload ? (nextA != '0) : (aCnt > AW'(1));

  always_ff @(posedge clk) begin
    if (reload) begin
      bCnt <= nextB;
      aCnt <= nextA;
    end else if (preEnd) begin
      bCnt <= bCnt - BW'(1);
      if (aCnt != '0) aCnt <= aCnt - AW'(1);
    end
  end

  a_r4_swallow_within_main: assert property (@(posedge clk) disable iff (rst)
    BW'(aCnt) <= bCnt);
  a_r1_main_nonzero: assert property (@(posedge clk) disable iff (rst)
    bCnt != '0);
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int BW      = 13,
  parameter int AW      = 6,
  parameter int MIN_B   = 3,
  parameter int DEF_B   = 3,
  parameter int DEF_A   = 0,
  parameter int DEF_SEL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    preSel,
  input  logic [BW-1:0] bLoad,
  input  logic [AW-1:0] aLoad,
  output logic          divOut,
  output logic          cfgBad
);
  psdStrobe_t    stb;
  logic          preEnd;
  logic [BW-1:0] nextB;
  logic [AW-1:0] nextA;

  psd_datapath #(
    .BW(BW), .AW(AW), .MIN_B(MIN_B),
    .DEF_B(DEF_B), .DEF_A(DEF_A), .DEF_SEL(DEF_SEL)
  ) u_dp (
    .clk(clk), .rst(rst), .preSel(preSel), .bIn(bLoad), .aIn(aLoad),
    .stb(stb), .preEnd(preEnd), .nextB(nextB), .nextA(nextA),
    .divOut(divOut), .cfgBad(cfgBad)
  );

  psd_control #(.BW(BW), .AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .preEnd(preEnd),
    .nextB(nextB), .nextA(nextA), .stb(stb)
  );
endmodule

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  preSel = 2'd2;
  logic [12:0] bLoad = 13'd4;
  logic [5:0]  aLoad = 6'd0;
  logic        divOut, cfgBad;
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;

  typedef struct packed {
    logic [1:0]  sel;
    logic [12:0] b;
    logic [5:0]  a;
    logic [31:0] n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 13'd3,   6'd0,  32'd24},
    '{2'd0, 13'd10,  6'd5,  32'd85},
    '{2'd1, 13'd5,   6'd5,  32'd85},
    '{2'd2, 13'd4,   6'd0,  32'd128},
    '{2'd3, 13'd3,   6'd3,  32'd195},
    '{2'd1, 13'd100, 6'd63, 32'd1663},
    '{2'd3, 13'd20,  6'd7,  32'd1287},
    '{2'd2, 13'd50,  6'd33, 32'd1633}
  };

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rst(rst), .preSel(preSel), .bLoad(bLoad), .aLoad(aLoad),
    .divOut(divOut), .cfgBad(cfgBad)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic nextPulse(output int t);
    do @(negedge clk); while (!divOut);
    t = cyc;
  endtask

  task automatic setCfg(input logic [1:0] s, input int b, input int a);
    preSel = s;
    bLoad  = 13'(b);
    aLoad  = 6'(a);
  endtask

  initial begin
    int t0, t1, t2;
    // R8: reset with valid inputs (P=32, B=4, A=0 -> 128)
    repeat (3) begin
      @(negedge clk);
      check("R8 divOut low in reset", int'(divOut), 0);
    end
    rst = 1'b0;
    t0 = cyc;
    nextPulse(t1);
    check("R8 first pulse after reset", t1 - t0, 128);
    @(negedge clk);
    check("R1 pulse one cycle wide", int'(divOut), 0);

    // R1 R2 R3: table of settings
    for (int i = 0; i < NV; i++) begin
      setCfg(VECS[i].sel, int'(VECS[i].b), int'(VECS[i].a));
      nextPulse(t1);
      nextPulse(t2);
      check($sformatf("R1 R2 R3 interval vec%0d", i), t2 - t1, int'(VECS[i].n));
    end

    // R5: flag decoding
    setCfg(2'd0, 2, 0);  #1; check("R5 B below 3", int'(cfgBad), 1);
    setCfg(2'd0, 5, 6);  #1; check("R5 A above B", int'(cfgBad), 1);
    setCfg(2'd0, 5, 5);  #1; check("R5 A equal B ok", int'(cfgBad), 0);
    setCfg(2'd0, 3, 0);  #1; check("R5 B at minimum ok", int'(cfgBad), 0);

    // R6: invalid settings ignored, ratio held (P=8, B=10, A=5 -> 85)
    setCfg(2'd0, 10, 5);
    nextPulse(t1);
    nextPulse(t2);
    setCfg(2'd3, 2, 0);
    nextPulse(t1);
    check("R6 hold with B too small", t1 - t2, 85);
    nextPulse(t2);
    check("R6 hold with B too small next", t2 - t1, 85);
    setCfg(2'd1, 5, 9);
    nextPulse(t1);
    nextPulse(t2);
    check("R6 hold with A above B", t2 - t1, 85);

    // R7: mid-period change keeps current period length
    setCfg(2'd0, 10, 5);
    nextPulse(t0);
    repeat (10) @(negedge clk);
    setCfg(2'd1, 4, 0);
    nextPulse(t1);
    check("R7 period in progress unchanged", t1 - t0, 85);
    nextPulse(t2);
    check("R7 new ratio after boundary", t2 - t1, 64);

    // R8: reset with invalid inputs falls back to default N=24
    @(negedge clk);
    rst = 1'b1;
    setCfg(2'd3, 1, 0);
    repeat (2) @(negedge clk);
    check("R8 divOut low in reset again", int'(divOut), 0);
    rst = 1'b0;
    t0 = cyc;
    nextPulse(t1);
    check("R8 default ratio after reset", t1 - t0, 24);
    nextPulse(t2);
    check("R6 default ratio held", t2 - t1, 24);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule